// File: doc/BRIEF.md
# Peripheral Set/Clear Register Bank

This block is the register front end that an on-chip peripheral places on a 32-bit peripheral bus. The bus moves only whole words. The block decodes a word offset inside the peripheral's 16 KB address window. It holds a mode register that software can read and write, and an enable vector. Software sets bits of the enable vector through one offset and clears them through another, so changing one bit never needs a read-modify-write. A status-readback offset returns the enable vector.

A command offset turns each bit written as one into a single-cycle pulse towards the peripheral core. Bits written as zero produce no pulse. The block also carries a transmit data word to the core with a write strobe, and it returns a receive data word from the core with a read strobe. A status offset returns the core's live status inputs.

A request is accepted in the cycle in which `req_valid` is high. All effects are registered. State changes and strobes appear in the cycle after the request. Read data appears on `rsp_rdata` in the cycle after a read and holds until the next read.

Top module: `regbank_top`

## Requirements
- R1: After reset, `mode_o`, `enable_o`, `cmd_pulse_o`, `tx_strobe_o`, `rx_strobe_o`, `tx_data_o` and `rsp_rdata` are all zero.
- R2: A write to offset 0x10 sets every enable bit whose written bit is one. Bits written as zero keep their value. The new value shows on `enable_o` in the cycle after the write.
- R3: A write to offset 0x14 clears every enable bit whose written bit is one. Bits written as zero keep their value.
- R4: A write to offset 0x00 drives `cmd_pulse_o` with the written word for exactly one cycle, the cycle after the write. Writing zero produces no pulse.
- R5: Offset 0x04 is a read/write mode register that resets to zero and appears on `mode_o`.
- R6: The access size input and address bits [1:0] are ignored. Every access is treated as a full-word access to the word selected by `req_addr[AW-1:2]`.
- R7: Only the bits set in the parameter MASK (default 0x00FF0FFF) exist in the mode and enable registers. Other bits cannot be written and read as zero. A write to an unmapped offset such as 0x08 changes nothing, and reads of unmapped offsets return zero.
- R8: A read of offset 0x20 returns `status_i` as sampled in the read cycle.
- R9: A write to offset 0x34 loads `tx_data_o` and raises `tx_strobe_o` for exactly the next cycle.
- R10: A read of offset 0x30 returns `rx_data_i` and raises `rx_strobe_o` for exactly the next cycle.
- R11: Offset 0x18 reads back the enable vector. Reads of offsets 0x00, 0x10, 0x14 and 0x34 return zero.
- R12: `rsp_rdata` updates only in the cycle after a read request. It keeps its value across idle cycles and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address within the peripheral window |
| req_size | input | 2 | Access size (ignored) |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid the cycle after a read |
| mode_o | output | 32 | Mode bits to the core |
| enable_o | output | 32 | Enable vector to the core |
| cmd_pulse_o | output | 32 | One-cycle command pulses |
| status_i | input | 32 | Live status from the core |
| rx_data_i | input | 32 | Receive data from the core |
| rx_strobe_o | output | 1 | Receive data consumed |
| tx_data_o | output | 32 | Transmit data to the core |
| tx_strobe_o | output | 1 | Transmit data written |

## Verification
The hardest effect to see from the ports is that one enable bit was left untouched by a set or clear write. To expose it, the bench first builds a mixed pattern through two set writes. It then clears an overlapping subset and compares both `enable_o` and the 0x18 readback against a model kept in the bench. Ignored stimulus is checked the same way. A byte-sized access at a misaligned address, a write to an unmapped offset, and writes of bits outside the mask are each followed by a readback of the mode and enable registers. Each pulse and strobe is sampled in the cycle after its request and again one cycle later, which proves that it lasts a single cycle.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    localparam int unsigned WIDX_CMD  = 0;
    localparam int unsigned WIDX_MODE = 1;
    localparam int unsigned WIDX_SET  = 4;
    localparam int unsigned WIDX_CLR  = 5;
    localparam int unsigned WIDX_ENRD = 6;
    localparam int unsigned WIDX_STAT = 8;
    localparam int unsigned WIDX_RX   = 12;
    localparam int unsigned WIDX_TX   = 13;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CMD,
        SEL_MODE,
        SEL_SET,
        SEL_CLR,
        SEL_ENRD,
        SEL_STAT,
        SEL_RX,
        SEL_TX
    } sel_e;

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
    import regbank_pkg::*;
#(
    parameter int AW = 14,
    localparam int WW = AW - 2
) (
    input  logic [WW-1:0] widx,
    output sel_e          sel
);

    always_comb begin
        if      (widx == WW'(WIDX_CMD))  sel = SEL_CMD;
        else if (widx == WW'(WIDX_MODE)) sel = SEL_MODE;
        else if (widx == WW'(WIDX_SET))  sel = SEL_SET;
        else if (widx == WW'(WIDX_CLR))  sel = SEL_CLR;
        else if (widx == WW'(WIDX_ENRD)) sel = SEL_ENRD;
        else if (widx == WW'(WIDX_STAT)) sel = SEL_STAT;
        else if (widx == WW'(WIDX_RX))   sel = SEL_RX;
        else if (widx == WW'(WIDX_TX))   sel = SEL_TX;
        else                             sel = SEL_NONE;
    end

endmodule

// File: rtl/regbank_shadow.sv
module regbank_shadow #(
    parameter int          DW   = 32,
    parameter logic [DW-1:0] MASK = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_we,
    input  logic          clr_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] en
);

    typedef struct packed {
        logic [DW-1:0] en;
    } shadow_t;

    shadow_t st_d, st_q;

    always_comb begin
        logic [DW-1:0] set_bits;
        logic [DW-1:0] clr_bits;
        set_bits = set_we ? wdata : '0;
        clr_bits = clr_we ? wdata : '0;
        st_d     = st_q;
        // clearing wins over setting for the same bit
        st_d.en  = ((st_q.en | set_bits) & ~clr_bits) & MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en = st_q.en;

endmodule

// File: rtl/regbank_strobe.sv
module regbank_strobe #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_we,
    input  logic          tx_we,
    input  logic          rx_re,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cmd_pulse,
    output logic          tx_strobe,
    output logic [DW-1:0] tx_data,
    output logic          rx_strobe
);

    typedef struct packed {
        logic [DW-1:0] pulse;
        logic          txs;
        logic [DW-1:0] txd;
        logic          rxs;
    } strobe_t;

    strobe_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = cmd_we ? wdata : '0;
        st_d.txs   = tx_we;
        st_d.rxs   = rx_re;
        if (tx_we) st_d.txd = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_pulse = st_q.pulse;
    assign tx_strobe = st_q.txs;
    assign tx_data   = st_q.txd;
    assign rx_strobe = st_q.rxs;

endmodule

// File: rtl/regbank_top.sv
module regbank_top
    import regbank_pkg::*;
#(
    parameter int          AW   = 14,
    parameter int          DW   = 32,
    parameter logic [DW-1:0] MASK = 32'h00FF_0FFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_size,
    input  logic [DW-1:0] req_wdata,
    output logic [DW-1:0] rsp_rdata,
    output logic [DW-1:0] mode_o,
    output logic [DW-1:0] enable_o,
    output logic [DW-1:0] cmd_pulse_o,
    input  logic [DW-1:0] status_i,
    input  logic [DW-1:0] rx_data_i,
    output logic          rx_strobe_o,
    output logic [DW-1:0] tx_data_o,
    output logic          tx_strobe_o
);

    typedef struct packed {
        logic [DW-1:0] mode;
        logic [DW-1:0] rdata;
    } top_t;

    top_t st_d, st_q;
    sel_e sel;
    logic wr, rd;
    logic [DW-1:0] rd_mux;
    logic unused_bits;

    // size and byte lanes play no part: every access is a word
    assign unused_bits = ^{req_size, req_addr[1:0]};

    assign wr = req_valid &&  req_write;
    assign rd = req_valid && !req_write;

    regbank_decode #(.AW(AW)) u_dec (
        .widx (req_addr[AW-1:2]),
        .sel  (sel)
    );

    regbank_shadow #(.DW(DW), .MASK(MASK)) u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (wr && sel == SEL_SET),
        .clr_we (wr && sel == SEL_CLR),
        .wdata  (req_wdata),
        .en     (enable_o)
    );

    regbank_strobe #(.DW(DW)) u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (wr && sel == SEL_CMD),
        .tx_we     (wr && sel == SEL_TX),
        .rx_re     (rd && sel == SEL_RX),
        .wdata     (req_wdata),
        .cmd_pulse (cmd_pulse_o),
        .tx_strobe (tx_strobe_o),
        .tx_data   (tx_data_o),
        .rx_strobe (rx_strobe_o)
    );

    always_comb begin
        case (sel)
            SEL_MODE: rd_mux = st_q.mode;
            SEL_ENRD: rd_mux = enable_o;
            SEL_STAT: rd_mux = status_i;
            SEL_RX:   rd_mux = rx_data_i;
            default:  rd_mux = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (wr && sel == SEL_MODE) st_d.mode  = req_wdata & MASK;
        if (rd)                    st_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_o    = st_q.mode;
    assign rsp_rdata = st_q.rdata;

endmodule

// File: rtl/regbank_checker.sv
module regbank_checker
    import regbank_pkg::*;
#(
    parameter int          AW   = 14,
    parameter int          DW   = 32,
    parameter logic [DW-1:0] MASK = 32'h00FF_0FFF
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_write,
    input logic [AW-1:0] req_addr,
    input logic [DW-1:0] rsp_rdata,
    input logic [DW-1:0] mode_o,
    input logic [DW-1:0] enable_o,
    input logic [DW-1:0] cmd_pulse_o,
    input logic          rx_strobe_o,
    input logic          tx_strobe_o
);

    localparam int WW = AW - 2;

    logic wr, rd;
    logic [WW-1:0] wi;
    assign wr = req_valid &&  req_write;
    assign rd = req_valid && !req_write;
    assign wi = req_addr[AW-1:2];

    a_r2_set_only_by_set_write: assert property (@(posedge clk) disable iff (!rst_n)
        ((enable_o & ~$past(enable_o)) != '0) |-> $past(wr && wi == WW'(WIDX_SET)));

    a_r3_clear_only_by_clr_write: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(enable_o) & ~enable_o) != '0) |-> $past(wr && wi == WW'(WIDX_CLR)));

    a_r4_pulse_follows_cmd_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pulse_o != '0) |-> $past(wr && wi == WW'(WIDX_CMD)));

    a_r5_mode_changes_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != $past(mode_o)) |-> $past(wr && wi == WW'(WIDX_MODE)));

    a_r7_masked_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o | enable_o) & ~MASK) == '0);

    a_r9_tx_strobe_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe_o |-> $past(wr && wi == WW'(WIDX_TX)));

    a_r10_rx_strobe_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe_o |-> $past(rd && wi == WW'(WIDX_RX)));

    a_r12_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd) |-> $stable(rsp_rdata));

endmodule

bind regbank_top regbank_checker #(.AW(AW), .DW(DW), .MASK(MASK)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .rsp_rdata   (rsp_rdata),
    .mode_o      (mode_o),
    .enable_o    (enable_o),
    .cmd_pulse_o (cmd_pulse_o),
    .rx_strobe_o (rx_strobe_o),
    .tx_strobe_o (tx_strobe_o)
);

// File: tb/tb_regbank_top.sv
`timescale 1ns/1ps
module tb_regbank_top;

    localparam int          AW   = 14;
    localparam logic [31:0] MASK = 32'h00FF_0FFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = 2'd2;
    logic [31:0]   req_wdata = '0;
    logic [31:0]   status_i = '0;
    logic [31:0]   rx_data_i = '0;
    logic [31:0]   rsp_rdata, mode_o, enable_o, cmd_pulse_o, tx_data_o;
    logic          rx_strobe_o, tx_strobe_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] en_model = '0;

    always #5 clk = ~clk;

    regbank_top #(.AW(AW), .DW(32), .MASK(MASK)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .mode_o(mode_o), .enable_o(enable_o),
        .cmd_pulse_o(cmd_pulse_o), .status_i(status_i), .rx_data_i(rx_data_i),
        .rx_strobe_o(rx_strobe_o), .tx_data_o(tx_data_o), .tx_strobe_o(tx_strobe_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive at a falling edge; returns at the next falling edge, after capture
    task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [1:0] sz);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_size = sz;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_wdata = '0; req_size = 2'd2;
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, input logic [1:0] sz, output logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
        @(negedge clk);
        req_valid = 1'b0; req_size = 2'd2;
        d = rsp_rdata;
    endtask

    task automatic t_reset();
        check("R1 mode", mode_o, 32'h0);
        check("R1 enable", enable_o, 32'h0);
        check("R1 pulse", cmd_pulse_o, 32'h0);
        check("R1 strobes", {30'h0, tx_strobe_o, rx_strobe_o}, 32'h0);
        check("R1 txdata", tx_data_o, 32'h0);
        check("R1 rdata", rsp_rdata, 32'h0);
    endtask

    task automatic t_mode();
        logic [31:0] r;
        bus_wr(14'h04, 32'hFFFF_FFFF, 2'd2);
        check("R7 mode masked", mode_o, MASK);
        bus_rd(14'h04, 2'd2, r);
        check("R5 mode readback", r, MASK);
        bus_wr(14'h04, 32'h0012_0345, 2'd2);
        check("R5 mode value", mode_o, 32'h0012_0345);
    endtask

    task automatic t_enable();
        logic [31:0] r;
        bus_wr(14'h10, 32'h0000_00F0, 2'd2); en_model |= 32'hF0;
        check("R2 set first", enable_o, en_model);
        bus_wr(14'h10, 32'hF000_F00F, 2'd2); en_model = (en_model | 32'hF000_F00F) & MASK;
        check("R2 set second, R7 mask", enable_o, en_model);
        bus_wr(14'h14, 32'h0000_003C, 2'd2); en_model &= ~32'h3C;
        check("R3 clear subset", enable_o, en_model);
        bus_rd(14'h18, 2'd2, r);
        check("R11 enable readback", r, en_model);
        bus_rd(14'h10, 2'd2, r);
        check("R11 set offset reads zero", r, 32'h0);
        bus_rd(14'h14, 2'd2, r);
        check("R11 clear offset reads zero", r, 32'h0);
        bus_wr(14'h14, 32'h0, 2'd2);
        check("R3 clear zero no effect", enable_o, en_model);
    endtask

    task automatic t_cmd();
        logic [31:0] r;
        bus_wr(14'h00, 32'h8001_0004, 2'd2);
        check("R4 pulse", cmd_pulse_o, 32'h8001_0004);
        @(negedge clk);
        check("R4 pulse one cycle", cmd_pulse_o, 32'h0);
        bus_wr(14'h00, 32'h0, 2'd2);
        check("R4 zero write no pulse", cmd_pulse_o, 32'h0);
        bus_rd(14'h00, 2'd2, r);
        check("R11 cmd reads zero", r, 32'h0);
    endtask

    task automatic t_size();
        logic [31:0] r;
        bus_wr(14'h07, 32'h1234_5678, 2'd0);
        check("R6 byte write at +3", mode_o, 32'h1234_5678 & MASK);
        bus_rd(14'h1A, 2'd1, r);
        check("R6 halfword read at +2", r, en_model);
    endtask

    task automatic t_status();
        logic [31:0] r;
        status_i = 32'hA5A5_5A5A;
        bus_rd(14'h20, 2'd2, r);
        check("R8 status a", r, 32'hA5A5_5A5A);
        status_i = 32'h0000_0001;
        bus_rd(14'h20, 2'd2, r);
        check("R8 status b", r, 32'h0000_0001);
    endtask

    task automatic t_tx_rx();
        logic [31:0] r;
        bus_wr(14'h34, 32'hDEAD_BEEF, 2'd2);
        check("R9 tx strobe", {31'h0, tx_strobe_o}, 32'h1);
        check("R9 tx data", tx_data_o, 32'hDEAD_BEEF);
        @(negedge clk);
        check("R9 tx strobe one cycle", {31'h0, tx_strobe_o}, 32'h0);
        bus_rd(14'h34, 2'd2, r);
        check("R11 tx reads zero", r, 32'h0);
        rx_data_i = 32'h0BAD_CAFE;
        bus_rd(14'h30, 2'd2, r);
        check("R10 rx data", r, 32'h0BAD_CAFE);
        check("R10 rx strobe", {31'h0, rx_strobe_o}, 32'h1);
        @(negedge clk);
        check("R10 rx strobe one cycle", {31'h0, rx_strobe_o}, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] r, m;
        m = mode_o;
        bus_wr(14'h08, 32'hFFFF_FFFF, 2'd2);
        check("R7 unmapped write mode", mode_o, m);
        check("R7 unmapped write enable", enable_o, en_model);
        bus_rd(14'h08, 2'd2, r);
        check("R7 unmapped read 08", r, 32'h0);
        bus_rd(14'h3C, 2'd2, r);
        check("R7 unmapped read 3C", r, 32'h0);
    endtask

    task automatic t_hold();
        logic [31:0] r;
        bus_rd(14'h04, 2'd2, r);
        check("R12 read value", r, mode_o);
        repeat (3) @(negedge clk);
        check("R12 hold idle", rsp_rdata, r);
        bus_wr(14'h04, 32'h0000_0000, 2'd2);
        check("R12 hold across write", rsp_rdata, r);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode();
        t_enable();
        t_cmd();
        t_size();
        t_status();
        t_tx_rx();
        t_unmapped();
        t_hold();
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule